// File: doc/BRIEF.md
# System I/O Register Block with Prescaled Event Counter

This block is a small bank of memory-mapped system registers for an FPGA-based SoC. It sits on a plain 32-bit register bus with a select, a write flag, a byte address and write data. Read data is returned in the same cycle. The bank drives a set of LED outputs and samples a set of push-button inputs. It also keeps two wall-clock style tick counters, one advancing a hundred times per second and one once per second. Their rates are derived from a clock-frequency parameter.

The central feature is an event counter that does not count raw clocks. A 32-bit down-counter decrements every clock. When it sits at zero, it reloads from a software-programmed reload register, and the event counter advances by one at that same clock edge. Software can therefore pick any period of `reload + 1` clocks. Every counter is writable, so software can preset or clear it. The live down-counter value can be read back.

A miscellaneous control register drives two active-low serial chip-select lines and a display reset line directly.

Top module: `sysio_regs`

## Requirements
- R1: While reset is held and right after it, every register reads zero: LED, both tick counters, the event counter, the reload value, the live prescaler and the control register. `ledOut`, `spiCsN` and `displayReset` are all zero.
- R2: The bus decodes word offsets from `busAddr[11:2]` as follows: LED 0x000, buttons 0x008, slow tick 0x010, fast tick 0x014, event counter 0x018, reload 0x020, live prescaler 0x024, control 0x04C. The LED register is read/write, and `ledOut` equals its low LED_W bits. Its upper read bits are zero.
- R3: At each clock edge where the live prescaler is nonzero and is not being written, it decreases by exactly one.
- R4: At each clock edge where the live prescaler is zero and is not being written, it takes the value the reload register held before that edge.
- R5: The event counter increases by one, wrapping modulo 2^32, at every edge where the live prescaler was zero. With a steady reload value N, this gives one increment per N+1 clocks.
- R6: A bus write to the slow tick, fast tick, event or live prescaler register loads the written value at that edge, overriding any count at that same edge. Counting resumes from that value at the next edge.
- R7: The fast tick counter increments once every CLK_HZ/100 clocks, first at the (CLK_HZ/100)-th edge after reset release. The slow tick counter increments once every CLK_HZ clocks in the same way. Writes to the counters do not shift this phase.
- R8: A read of the button register returns `buttonsIn` as it was two clock edges earlier, zero-extended. Writes to the button register change nothing.
- R9: The control register holds bits [9:0], and its upper read bits are zero. `spiCsN[0]` follows bit 8, `spiCsN[1]` follows bit 9, and `displayReset` follows bit 3.
- R10: Reads of any undecoded offset return zero, and writes to undecoded offsets change no register. Address bits [1:0] are ignored, and reads with `busSel` low return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of a read |
| buttonsIn | input | BTN_W | Raw button levels |
| ledOut | output | LED_W | LED drive |
| spiCsN | output | 2 | Active-low serial chip selects |
| displayReset | output | 1 | Display reset line |

## Verification
A wrong prescaler state shows up at the ports one read later, as a live prescaler value that differs from the model's. It also shows in the event counter, which drifts by one count at the first zero that lands on the wrong edge. Errors in a tick divider show only at tick edges, so they take up to CLK_HZ clocks to surface. For that reason the slow counter is watched over more than a full period. Decode and control-register faults appear at once, on the output pins or on the next read of the affected offset.

// File: rtl/sysio_pkg.sv
package sysio_pkg;

  localparam int DATA_W = 32;
  localparam int MISC_W = 10;

  localparam int MISC_DRST_BIT = 3;
  localparam int MISC_CS0_BIT  = 8;
  localparam int MISC_CS1_BIT  = 9;

  // word offsets (byte offset / 4)
  localparam int OFS_LED    = 'h00;
  localparam int OFS_BTN    = 'h02;
  localparam int OFS_SLOW   = 'h04;
  localparam int OFS_FAST   = 'h05;
  localparam int OFS_CYC    = 'h06;
  localparam int OFS_RELOAD = 'h08;
  localparam int OFS_PSCNT  = 'h09;
  localparam int OFS_MISC   = 'h13;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_LED, SEL_BTN, SEL_SLOW, SEL_FAST,
    SEL_CYC, SEL_RELOAD, SEL_PSCNT, SEL_MISC
  } regSel_e;

  typedef struct packed {
    logic    wrLed;
    logic    wrSlow;
    logic    wrFast;
    logic    wrCyc;
    logic    wrReload;
    logic    wrPs;
    logic    wrMisc;
    regSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/sysio_tick_div.sv
module sysio_tick_div #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rstN,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase;

  assign tick = (phase == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     phase <= '0;
    else if (tick) phase <= '0;
    else           phase <= phase + 1'b1;
  end
endmodule

// File: rtl/sysio_ctrl.sv
module sysio_ctrl
  import sysio_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobes_t          stb
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] wordIdx;
  logic [1:0]        unusedAddrBits;
  regSel_e           decSel;
  logic              wrHit;

  assign wordIdx        = busAddr[ADDR_W-1:2];
  assign unusedAddrBits = busAddr[1:0];
  assign wrHit          = busSel && busWr;

  always_comb begin
    decSel = SEL_NONE;
    case (wordIdx)
      WIDX_W'(OFS_LED):    decSel = SEL_LED;
      WIDX_W'(OFS_BTN):    decSel = SEL_BTN;
      WIDX_W'(OFS_SLOW):   decSel = SEL_SLOW;
      WIDX_W'(OFS_FAST):   decSel = SEL_FAST;
      WIDX_W'(OFS_CYC):    decSel = SEL_CYC;
      WIDX_W'(OFS_RELOAD): decSel = SEL_RELOAD;
      WIDX_W'(OFS_PSCNT):  decSel = SEL_PSCNT;
      WIDX_W'(OFS_MISC):   decSel = SEL_MISC;
      default:             decSel = SEL_NONE;
    endcase
  end

  always_comb begin
    stb          = '0;
    stb.rdSel    = (busSel && !busWr) ? decSel : SEL_NONE;
    stb.wrLed    = wrHit && (decSel == SEL_LED);
    stb.wrSlow   = wrHit && (decSel == SEL_SLOW);
    stb.wrFast   = wrHit && (decSel == SEL_FAST);
    stb.wrCyc    = wrHit && (decSel == SEL_CYC);
    stb.wrReload = wrHit && (decSel == SEL_RELOAD);
    stb.wrPs     = wrHit && (decSel == SEL_PSCNT);
    stb.wrMisc   = wrHit && (decSel == SEL_MISC);
  end
endmodule

// File: rtl/sysio_datapath.sv
module sysio_datapath
  import sysio_pkg::*;
#(
  parameter int LED_W    = 8,
  parameter int BTN_W    = 4,
  parameter int DIV_FAST = 10,
  parameter int DIV_SLOW = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BTN_W-1:0]  buttonsIn,
  output logic [DATA_W-1:0] rdata,
  output logic [LED_W-1:0]  ledQ,
  output logic [MISC_W-1:0] miscQ,
  output logic [DATA_W-1:0] psCntQ,
  output logic [DATA_W-1:0] cycQ,
  output logic [DATA_W-1:0] reloadQ
);
  localparam int NTICK = 2;  // index 0 fast, 1 slow

  logic [BTN_W-1:0]           btnMeta, btnSync;
  logic [NTICK-1:0]           tickPulse, tickWr;
  logic [NTICK-1:0][DATA_W-1:0] tickCnt;
  logic                       psZero;

  assign tickWr = {stb.wrSlow, stb.wrFast};
  assign psZero = (psCntQ == '0);

  for (genvar g = 0; g < NTICK; g++) begin : g_tick
    localparam int DIVG = (g == 0) ? DIV_FAST : DIV_SLOW;
    sysio_tick_div #(.DIV(DIVG)) u_div (
      .clk  (clk),
      .rstN (rstN),
      .tick (tickPulse[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else begin
      for (int i = 0; i < NTICK; i++) begin
        if (tickWr[i])         tickCnt[i] <= wdata;
        else if (tickPulse[i]) tickCnt[i] <= tickCnt[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCntQ  <= '0;
      cycQ    <= '0;
      reloadQ <= '0;
    end else begin
      if (stb.wrReload) reloadQ <= wdata;
      if (stb.wrPs)     psCntQ  <= wdata;
      else if (psZero)  psCntQ  <= reloadQ;
      else              psCntQ  <= psCntQ - 1'b1;
      if (stb.wrCyc)    cycQ    <= wdata;
      else if (psZero)  cycQ    <= cycQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ledQ    <= '0;
      miscQ   <= '0;
      btnMeta <= '0;
      btnSync <= '0;
    end else begin
      btnMeta <= buttonsIn;
      btnSync <= btnMeta;
      if (stb.wrLed)  ledQ  <= wdata[LED_W-1:0];
      if (stb.wrMisc) miscQ <= wdata[MISC_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (stb.rdSel)
      SEL_LED:    rdata = DATA_W'(ledQ);
      SEL_BTN:    rdata = DATA_W'(btnSync);
      SEL_SLOW:   rdata = tickCnt[1];
      SEL_FAST:   rdata = tickCnt[0];
      SEL_CYC:    rdata = cycQ;
      SEL_RELOAD: rdata = reloadQ;
      SEL_PSCNT:  rdata = psCntQ;
      SEL_MISC:   rdata = DATA_W'(miscQ);
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/sysio_regs.sv
module sysio_regs
  import sysio_pkg::*;
#(
  parameter int CLK_HZ = 1000,
  parameter int ADDR_W = 12,
  parameter int LED_W  = 8,
  parameter int BTN_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [BTN_W-1:0]  buttonsIn,
  output logic [LED_W-1:0]  ledOut,
  output logic [1:0]        spiCsN,
  output logic              displayReset
);
  localparam int DIV_FAST = (CLK_HZ >= 100) ? CLK_HZ / 100 : 1;
  localparam int DIV_SLOW = (CLK_HZ >= 1) ? CLK_HZ : 1;

  strobes_t          stb;
  logic [MISC_W-1:0] miscQ;
  logic [31:0]       psCntQ, cycQ, reloadQ;

  sysio_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .stb     (stb)
  );

  sysio_datapath #(
    .LED_W    (LED_W),
    .BTN_W    (BTN_W),
    .DIV_FAST (DIV_FAST),
    .DIV_SLOW (DIV_SLOW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wdata     (busWdata),
    .buttonsIn (buttonsIn),
    .rdata     (busRdata),
    .ledQ      (ledOut),
    .miscQ     (miscQ),
    .psCntQ    (psCntQ),
    .cycQ      (cycQ),
    .reloadQ   (reloadQ)
  );

  assign spiCsN       = {miscQ[MISC_CS1_BIT], miscQ[MISC_CS0_BIT]};
  assign displayReset = miscQ[MISC_DRST_BIT];
endmodule

// File: rtl/sysio_regs_chk.sv
module sysio_regs_chk
  import sysio_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busRdata,
  input logic [31:0]       psCntQ,
  input logic [31:0]       cycQ,
  input logic [31:0]       reloadQ,
  input logic [1:0]        spiCsN,
  input logic              displayReset
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] idx;
  logic              wrAny, wrPs, wrCyc, wrMisc, known;

  assign idx    = busAddr[ADDR_W-1:2];
  assign wrAny  = busSel && busWr;
  assign wrPs   = wrAny && (idx == WIDX_W'(OFS_PSCNT));
  assign wrCyc  = wrAny && (idx == WIDX_W'(OFS_CYC));
  assign wrMisc = wrAny && (idx == WIDX_W'(OFS_MISC));
  assign known  = (idx == WIDX_W'(OFS_LED))   || (idx == WIDX_W'(OFS_BTN))    ||
                  (idx == WIDX_W'(OFS_SLOW))  || (idx == WIDX_W'(OFS_FAST))   ||
                  (idx == WIDX_W'(OFS_CYC))   || (idx == WIDX_W'(OFS_RELOAD)) ||
                  (idx == WIDX_W'(OFS_PSCNT)) || (idx == WIDX_W'(OFS_MISC));

  assert_ps_decrement_R3: assert property (@(posedge clk) disable iff (!rstN)
    (psCntQ != 0 && !wrPs) |=> (psCntQ == $past(psCntQ) - 32'd1));

  assert_ps_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    (psCntQ == 0 && !wrPs) |=> (psCntQ == $past(reloadQ)));

  assert_cyc_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (psCntQ == 0 && !wrCyc) |=> (cycQ == $past(cycQ) + 32'd1));

  assert_cyc_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (psCntQ != 0 && !wrCyc) |=> $stable(cycQ));

  assert_misc_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !wrMisc |=> ($stable(spiCsN) && $stable(displayReset)));

  assert_undef_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && !known) |-> (busRdata == 32'd0));
endmodule

bind sysio_regs sysio_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .busSel       (busSel),
  .busWr        (busWr),
  .busAddr      (busAddr),
  .busRdata     (busRdata),
  .psCntQ       (psCntQ),
  .cycQ         (cycQ),
  .reloadQ      (reloadQ),
  .spiCsN       (spiCsN),
  .displayReset (displayReset)
);

// File: tb/sysio_regs_bench.sv
`timescale 1ns/1ps
module sysio_regs_bench;
  localparam int CLK_HZ = 2000;
  localparam int DF     = CLK_HZ / 100;
  localparam int DS     = CLK_HZ;
  localparam int LED_W  = 8;
  localparam int BTN_W  = 4;

  logic        clk = 0;
  logic        rstN = 0;
  logic        busSel = 0, busWr = 0;
  logic [11:0] busAddr = 0;
  logic [31:0] busWdata = 0;
  logic [31:0] busRdata;
  logic [BTN_W-1:0] buttonsIn = 0;
  logic [LED_W-1:0] ledOut;
  logic [1:0]  spiCsN;
  logic        displayReset;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sysio_regs #(.CLK_HZ(CLK_HZ), .ADDR_W(12), .LED_W(LED_W), .BTN_W(BTN_W)) u_sysio_regs (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .buttonsIn(buttonsIn),
    .ledOut(ledOut), .spiCsN(spiCsN), .displayReset(displayReset)
  );

  // reference model built from the requirements
  logic [31:0] mLed, mSlow, mFast, mCyc, mRel, mPs, mMisc;
  logic [BTN_W-1:0] mB1, mB2;
  int mDivF, mDivS;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLed <= 0; mSlow <= 0; mFast <= 0; mCyc <= 0; mRel <= 0; mPs <= 0; mMisc <= 0;
      mB1 <= 0; mB2 <= 0; mDivF <= 0; mDivS <= 0;
    end else begin
      mB1 <= buttonsIn; mB2 <= mB1;
      mDivF <= (mDivF == DF - 1) ? 0 : mDivF + 1;
      mDivS <= (mDivS == DS - 1) ? 0 : mDivS + 1;
      if (mDivF == DF - 1) mFast <= mFast + 1;
      if (mDivS == DS - 1) mSlow <= mSlow + 1;
      if (mPs == 0) begin mPs <= mRel; mCyc <= mCyc + 1; end
      else mPs <= mPs - 1;
      if (busSel && busWr) begin
        case (busAddr[11:2])
          10'h00: mLed  <= {24'd0, busWdata[7:0]};
          10'h04: mSlow <= busWdata;
          10'h05: mFast <= busWdata;
          10'h06: mCyc  <= busWdata;
          10'h08: mRel  <= busWdata;
          10'h09: mPs   <= busWdata;
          10'h13: mMisc <= {22'd0, busWdata[9:0]};
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] modelRead(input logic [11:0] a);
    case (a[11:2])
      10'h00: return mLed;
      10'h02: return {28'd0, mB2};
      10'h04: return mSlow;
      10'h05: return mFast;
      10'h06: return mCyc;
      10'h08: return mRel;
      10'h09: return mPs;
      10'h13: return mMisc;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tagFor(input logic [11:0] a);
    case (a[11:2])
      10'h00: return "R2";
      10'h02: return "R8";
      10'h04, 10'h05: return "R7";
      10'h06: return "R5";
      10'h08: return "R4";
      10'h09: return "R3";
      10'h13: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkPins(input string tag);
    check(tag, "ledOut", 32'(ledOut), mLed);
    check("R9", "spiCsN", 32'(spiCsN), {30'd0, mMisc[9], mMisc[8]});
    check("R9", "displayReset", 32'(displayReset), {31'd0, mMisc[3]});
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    @(negedge clk);
    buttonsIn = 4'($urandom);
    busSel = 1; busWr = 0; busAddr = a;
    #1;
    check(tag, $sformatf("read %h", a), busRdata, modelRead(a));
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    buttonsIn = 4'($urandom);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  localparam logic [11:0] ADDRS [14] = '{12'h000, 12'h008, 12'h010, 12'h014, 12'h018,
    12'h020, 12'h024, 12'h04C, 12'h004, 12'h01C, 12'h050, 12'hFFC, 12'h04F, 12'h023};

  initial begin
    void'($urandom(32'h5EED_1234));
    // R1: reset state while reset held
    repeat (2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      busSel = 1; busWr = 0; busAddr = ADDRS[i]; #1;
      check("R1", $sformatf("reset read %h", ADDRS[i]), busRdata, 32'd0);
    end
    checkPins("R1");
    @(negedge clk); rstN = 1;
    for (int i = 0; i < 8; i++) rd(ADDRS[i], "R1");

    // R2 LED and R9 control pins
    wr(12'h000, 32'hDEAD_BEA5); rd(12'h000, "R2"); checkPins("R2");
    wr(12'h04C, 32'h0000_0308); rd(12'h04C, "R9"); checkPins("R9");
    wr(12'h04C, 32'hFFFF_FFFF); rd(12'h04C, "R9"); checkPins("R9");
    wr(12'h04C, 32'h0000_0100); @(negedge clk); checkPins("R9");

    // R3 R4 R5: reload 3, watch period of 4
    wr(12'h020, 32'd3);
    wr(12'h024, 32'd0);
    for (int i = 0; i < 10; i++) begin rd(12'h024, "R3"); rd(12'h018, "R5"); end
    // R6: event counter wrap and write priority
    wr(12'h018, 32'hFFFF_FFFF);
    for (int i = 0; i < 6; i++) rd(12'h018, "R6");
    wr(12'h014, 32'h1234_0000); rd(12'h014, "R6");
    wr(12'h010, 32'h0000_00FE); rd(12'h010, "R6");
    wr(12'h024, 32'd7); rd(12'h024, "R6");

    // R8: button write ignored, R10 undefined writes ignored
    wr(12'h008, 32'hFFFF_FFFF); rd(12'h008, "R8"); rd(12'h008, "R8");
    wr(12'h004, 32'hAAAA_AAAA); rd(12'h004, "R10"); rd(12'h000, "R10");
    wr(12'h050, 32'h5555_5555); rd(12'h04F, "R10"); rd(12'h020, "R10");
    @(negedge clk); busSel = 0; busWr = 0; busAddr = 12'h000; #1;
    check("R10", "read with busSel low", busRdata, 32'd0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      a = ADDRS[$urandom_range(0, 13)];
      d = $urandom;
      if (a[11:2] == 10'h08 || a[11:2] == 10'h09) d = d & 32'h1F;
      if ($urandom_range(0, 3) == 0) wr(a, d);
      else rd(a, tagFor(a));
      if (n % 16 == 0) checkPins("R2");
    end

    // R7: idle watch of the slow counter across more than one period
    for (int i = 0; i < DS + 100; i++) begin
      rd((i % 2 == 0) ? 12'h010 : 12'h014, "R7");
    end
    finishRun();
  end
endmodule